// File: doc/BRIEF.md
# H-Bridge Control and Fault Logic

This block is the digital control core of a two-leg full-bridge motor driver. Each leg, A and B, has a high-side and a low-side switch. A direction bit per leg selects which switch of that leg conducts, and together the two bits select one of four bridge modes: drive clockwise, drive counter-clockwise, brake to supply, or brake to ground. A shared PWM input chops only the low-side switches to control speed. A per-leg enable, held low from outside, turns both switches of that leg off and leaves its output floating.

Protection runs alongside the mode logic. A high-side over-temperature flag or a low-side saturation flag on a leg shuts that leg off, latches the shutdown, and raises that leg's diagnostic pull-down. The latch holds until the fault has gone and the leg's direction bit then rises. A supply-window flag turns all four switches off for as long as it is set, without latching. In load-test mode the gate drives are off except that each direction bit drives its own high side, and a load-open indication raises the diagnostic of the leg opposite the powered one. Whenever a leg's direction bit changes, that leg is held fully off for a programmable number of clock ticks before the new switch turns on. All inputs pass through two-flop synchronizers, and the outputs are registered.

Top module: `hbridge_ctrl`

## Requirements
- R1: With both enables high, PWM high and no fault, each leg has its high switch on and its low switch off when its direction bit is 1, and the reverse when it is 0. This gives the four modes 11 = brake to supply, 10 = clockwise, 01 = counter-clockwise and 00 = brake to ground, where bit order is {dir_a, dir_b}.
- R2: While PWM is 0, both low switches are off and the high switches are unchanged. When PWM returns to 1, each low switch follows its direction bit again.
- R3: A leg whose enable is 0 has both switches off. The other leg is unaffected.
- R4: An over-temperature or saturation flag on a leg turns both switches of that leg off and sets that leg's diagnostic output to 1, which means pull low. The other leg is unaffected.
- R5: After a fault, the leg stays off with its diagnostic at 1 until the fault flags are clear and the leg's direction bit then goes from 0 to 1. A rising edge that occurs while the fault is still present does not release the leg.
- R6: While supply_bad is 1, all four switches are off. Normal operation resumes once it clears, with no latching.
- R7: In test mode, both low switches are off and each high switch follows its own direction bit. With load_open set, the diagnostic of leg B is 1 while dir_a is 1, and the diagnostic of leg A is 1 while dir_b is 1.
- R8: When a leg's synchronized direction bit changes, both switches of that leg stay off for DELAY_CYC+1 clock cycles before its new switch turns on. A leg whose direction did not change keeps its switches as they were.
- R9: The high and low switch of one leg are never on in the same cycle.
- R10: Under reset, all four switches are off and both diagnostic outputs are 0. An input change reaches the outputs on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Direction bit for leg A (1 = high switch, 0 = low switch) |
| dir_b | input | 1 | Direction bit for leg B |
| pwm | input | 1 | Low-side modulation input |
| en_a | input | 1 | Leg A enable, active high |
| en_b | input | 1 | Leg B enable, active high |
| ot_a | input | 1 | Leg A high-side over-temperature flag |
| sat_a | input | 1 | Leg A low-side saturation flag |
| ot_b | input | 1 | Leg B high-side over-temperature flag |
| sat_b | input | 1 | Leg B low-side saturation flag |
| supply_bad | input | 1 | Supply outside allowed window |
| test_mode | input | 1 | Load-test mode select |
| load_open | input | 1 | Load-disconnect indication during test mode |
| hs_a | output | 1 | Leg A high switch gate enable |
| ls_a | output | 1 | Leg A low switch gate enable |
| hs_b | output | 1 | Leg B high switch gate enable |
| ls_b | output | 1 | Leg B low switch gate enable |
| diag_a | output | 1 | Leg A diagnostic pull-down request |
| diag_b | output | 1 | Leg B diagnostic pull-down request |

## Verification
The mode table is swept over all four direction pairs with PWM both high and low. This separates direction decoding from low-side gating. It is then swept over all four enable pairs for every direction pair, which shows that each enable acts only on its own leg. A single-leg direction change is sampled on the last held-off cycle and on the first cycle the new switch is on, so an off-by-one in the delay counter shows up, and the unchanged leg is checked during the same window. Fault sequences tell a rising edge after the fault clears (release) apart from one while the fault is present (no release). Supply and test-mode patterns separate the unlatched shutdown from the latched one and show which leg's diagnostic the load-open indication reaches.

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl #(
  parameter int DELAY_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_a,
  input  logic dir_b,
  input  logic pwm,
  input  logic en_a,
  input  logic en_b,
  input  logic ot_a,
  input  logic sat_a,
  input  logic ot_b,
  input  logic sat_b,
  input  logic supply_bad,
  input  logic test_mode,
  input  logic load_open,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b,
  output logic diag_a,
  output logic diag_b
);
  localparam int NIN = 12;
  localparam int CW  = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(DELAY_CYC);

  logic [NIN-1:0] raw, s1, s2;
  assign raw = {dir_b, dir_a, pwm, en_b, en_a, ot_b, sat_b, ot_a, sat_a,
                supply_bad, test_mode, load_open};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  logic [1:0] sdir, sen, fsrc;
  logic       spwm, ssup, stest, sload;
  assign sdir  = s2[11:10];
  assign spwm  = s2[9];
  assign sen   = s2[8:7];
  assign fsrc  = {s2[6] | s2[5], s2[4] | s2[3]};
  assign ssup  = s2[2];
  assign stest = s2[1];
  assign sload = s2[0];

  logic [1:0]    dir_q, flt, mask, chg, rise, hold, live_mask;
  logic [CW-1:0] cnt;

  assign chg       = sdir ^ dir_q;
  assign rise      = sdir & ~dir_q;
  assign live_mask = (cnt != '0) ? mask : 2'b00;
  assign hold      = chg | live_mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '0;
      cnt   <= '0;
      mask  <= '0;
      flt   <= '0;
    end else begin
      dir_q <= sdir;
      flt   <= fsrc | (flt & ~rise);
      if (|chg) begin
        cnt  <= LOAD;
        mask <= live_mask | chg;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        mask <= '0;
      end
    end

  logic [1:0] hs_d, ls_d, dg_d, hs_q, ls_q, dg_q;

  for (genvar i = 0; i < 2; i++) begin : g_leg
    logic off;
    assign off     = ssup | ~sen[i] | flt[i] | fsrc[i] | hold[i];
    assign hs_d[i] = ~off & sdir[i];
    assign ls_d[i] = ~off & ~sdir[i] & spwm & ~stest;
    assign dg_d[i] = flt[i] | fsrc[i] | (stest & sload & sdir[1-i]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_q <= '0;
      ls_q <= '0;
      dg_q <= '0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
      dg_q <= dg_d;
    end

  assign hs_a   = hs_q[0];
  assign ls_a   = ls_q[0];
  assign hs_b   = hs_q[1];
  assign ls_b   = ls_q[1];
  assign diag_a = dg_q[0];
  assign diag_b = dg_q[1];
endmodule

module hbridge_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hs_a,
  input logic       ls_a,
  input logic       hs_b,
  input logic       ls_b,
  input logic       diag_a,
  input logic       diag_b,
  input logic [1:0] fsrc,
  input logic [1:0] flt,
  input logic [1:0] rise,
  input logic [1:0] sen,
  input logic       spwm,
  input logic       ssup,
  input logic       stest
);
  a_r9_no_shoot_a: assert property (@(posedge clk) disable iff (!rst_n) !(hs_a && ls_a));
  a_r9_no_shoot_b: assert property (@(posedge clk) disable iff (!rst_n) !(hs_b && ls_b));
  a_r2_pwm_low: assert property (@(posedge clk) disable iff (!rst_n) !spwm |=> (!ls_a && !ls_b));
  a_r3_enable_a: assert property (@(posedge clk) disable iff (!rst_n) !sen[0] |=> (!hs_a && !ls_a));
  a_r3_enable_b: assert property (@(posedge clk) disable iff (!rst_n) !sen[1] |=> (!hs_b && !ls_b));
  a_r4_fault_a: assert property (@(posedge clk) disable iff (!rst_n) fsrc[0] |=> (!hs_a && !ls_a && diag_a));
  a_r4_fault_b: assert property (@(posedge clk) disable iff (!rst_n) fsrc[1] |=> (!hs_b && !ls_b && diag_b));
  a_r5_latched_a: assert property (@(posedge clk) disable iff (!rst_n) (flt[0] && !rise[0]) |=> (!hs_a && !ls_a && diag_a));
  a_r5_latched_b: assert property (@(posedge clk) disable iff (!rst_n) (flt[1] && !rise[1]) |=> (!hs_b && !ls_b && diag_b));
  a_r6_supply: assert property (@(posedge clk) disable iff (!rst_n) ssup |=> (!hs_a && !ls_a && !hs_b && !ls_b));
  a_r7_test_no_ls: assert property (@(posedge clk) disable iff (!rst_n) stest |=> (!ls_a && !ls_b));
endmodule

bind hbridge_ctrl hbridge_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b),
  .diag_a(diag_a), .diag_b(diag_b), .fsrc(fsrc), .flt(flt), .rise(rise),
  .sen(sen), .spwm(spwm), .ssup(ssup), .stest(stest)
);

// File: tb/hbridge_ctrl_tb.sv
module hbridge_ctrl_tb;
  localparam int DLY = 6;
  logic clk = 0, rst_n = 0;
  logic dir_a = 0, dir_b = 0, pwm = 0, en_a = 0, en_b = 0;
  logic ot_a = 0, sat_a = 0, ot_b = 0, sat_b = 0, supply_bad = 0, test_mode = 0, load_open = 0;
  logic hs_a, ls_a, hs_b, ls_b, diag_a, diag_b;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hbridge_ctrl #(.DELAY_CYC(DLY)) u_dut (.*);

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {hs_a,ls_a,hs_b,ls_b,diag_a,diag_b} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {hs_a, ls_a, hs_b, ls_b, diag_a, diag_b};
  endfunction

  function automatic logic [5:0] norm(input logic ea, eb, da, db, p);
    return {ea & da, ea & ~da & p, eb & db, eb & ~db & p, 2'b00};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R10 reset", outs(), 6'b0);
    rst_n = 1;
    en_a = 1; en_b = 1; pwm = 1;
    step(2);
    chk("R10 latency not yet", outs(), 6'b000000);
    step(1);
    chk("R10 latency third edge", outs(), 6'b010100);

    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 2; p++) begin
        dir_a = d[1]; dir_b = d[0]; pwm = p[0];
        step(14);
        chk(p ? "R1 mode table" : "R2 pwm low", outs(), norm(1, 1, d[1], d[0], p[0]));
        chk("R9 no overlap", {1'b0, hs_a & ls_a, 1'b0, hs_b & ls_b, 2'b0}, 6'b0);
      end

    dir_a = 0; dir_b = 0; pwm = 1;
    step(14);
    dir_a = 1;
    step(5);
    chk("R8 changed leg held off", outs(), 6'b000100);
    step(4);
    chk("R8 last held cycle", outs(), 6'b000100);
    step(1);
    chk("R8 first on cycle", outs(), 6'b100100);

    for (int d = 0; d < 4; d++) begin
      dir_a = d[1]; dir_b = d[0];
      for (int e = 0; e < 4; e++) begin
        en_a = e[1]; en_b = e[0];
        step(14);
        chk("R3 enable sweep", outs(), norm(e[1], e[0], d[1], d[0], 1));
      end
    end

    en_a = 1; en_b = 1; dir_a = 1; dir_b = 0;
    step(14);
    ot_a = 1;
    step(5);
    chk("R4 overtemp latches leg A", outs(), 6'b000110);
    ot_a = 0;
    step(14);
    chk("R5 still latched after clear", outs(), 6'b000110);
    dir_a = 0;
    step(14);
    chk("R5 falling edge no release", outs(), 6'b000110);
    dir_a = 1;
    step(14);
    chk("R5 rising edge releases", outs(), 6'b100100);

    sat_b = 1;
    step(5);
    chk("R4 saturation latches leg B", outs(), 6'b100001);
    dir_b = 1;
    step(5);
    dir_b = 0;
    step(5);
    dir_b = 1;
    step(5);
    sat_b = 0;
    step(14);
    chk("R5 rise during fault ignored", outs(), 6'b100001);
    dir_b = 0;
    step(14);
    dir_b = 1;
    step(14);
    chk("R5 release leg B", outs(), 6'b101000);

    dir_b = 0;
    step(14);
    supply_bad = 1;
    step(5);
    chk("R6 supply off", outs(), 6'b000000);
    supply_bad = 0;
    step(5);
    chk("R6 resumes unlatched", outs(), 6'b100100);

    test_mode = 1;
    step(5);
    chk("R7 test mode high only", outs(), 6'b100000);
    load_open = 1;
    step(5);
    chk("R7 load open diag B", outs(), 6'b100001);
    dir_a = 0; dir_b = 1;
    step(14);
    chk("R7 load open diag A", outs(), 6'b001010);
    test_mode = 0; load_open = 0;
    step(5);
    chk("R7 exit test mode", outs(), 6'b011000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule